// File: doc/BRIEF.md
# Effective-code matched filter bank

This block produces the code-matched-filter statistic for every user of a multi-user spread-spectrum receiver. Each statistic is the inner product of a shared window of received chip samples with that user's effective spreading vector. That vector is estimated upstream and already absorbs the multipath delays and gains, so the block never handles individual paths, never divides or takes a square root, and never realigns the window to any single user's bit timing.

Chip samples stream into a window register that always holds the most recent two-bit span (twice the spreading gain, 62 chips by default). Coefficients are loaded into an internal memory through a write port that takes a user index and a chip index. A start strobe freezes the window and the coefficients. The block then works through the users in groups of `LANES`, with two by default. Each lane runs one signed multiply-accumulate per chip into a saturating accumulator. The results leave one per cycle in ascending user order, and a done pulse follows the last one.

Top module: `ecmf_bank`

## Requirements
- R1: For user u, the statistic is the sum over j = 0..CHIPS-1 of coef[u][j] * win[j]. Here win[j] is the j-th oldest of the last CHIPS samples accepted on `smp_data`, and all users see the same window.
- R2: The chip products are added in ascending chip order into a 24-bit signed accumulator. After each addition the partial sum is clamped to [-2^23, 2^23-1] and never wraps.
- R3: The emitted statistic is the final accumulator clamped to the 16-bit signed range [-32768, 32767].
- R4: `start` is accepted only while idle. Users are processed in groups of LANES consecutive indices. Group g yields its first statistic exactly CHIPS + g*(CHIPS+LANES) cycles after the accepted start edge, and the statistics of a group follow one per cycle in ascending user order on `stat_user`.
- R5: `done` is high for exactly one cycle, the cycle after the statistic of the last user, and it is never high together with `stat_valid`. Outside a run neither output is asserted.
- R6: A coefficient write (`coef_we` high) is ignored from the cycle a start is accepted until the cycle after `done`.
- R7: Samples offered on `smp_valid` in that same busy interval are ignored and do not enter the window.
- R8: A `start` pulse during a run has no effect on the timing or the values of that run.
- R9: A coefficient write whose user index is NUM_USERS or more, or whose chip index is CHIPS or more, changes no stored coefficient.
- R10: After reset no output is asserted and the window holds zeros, so a run before any sample gives 0 for every user.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Shift `smp_data` into the window |
| smp_data | input | 12 | Signed chip sample |
| coef_we | input | 1 | Coefficient write enable |
| coef_user | input | 4 | User index of the write |
| coef_chip | input | 6 | Chip index of the write |
| coef_data | input | 12 | Signed coefficient value |
| start | input | 1 | Begin a pass over all users |
| stat_valid | output | 1 | `stat_user`/`stat_data` carry a result |
| stat_user | output | 4 | User index of the result |
| stat_data | output | 16 | Signed saturated statistic |
| done | output | 1 | One-cycle pulse after the last result |

## Verification
The hardest case to reach from the ports is a partial sum that saturates at the 24-bit rail partway through the window and is then pulled back by later negative products. Here a wrapping adder and a clamping adder end at different values. To reach it, the bench holds the window at full-scale positive samples and gives one user maximum positive coefficients over the first half of the window and maximum negative coefficients over the second half. Neighbouring users get full-scale same-sign vectors and a mid-size vector that fits in 24 bits but not in 16, which separates the two clamps. A second hard case is stimulus that arrives mid-run. The bench fires writes, samples and a stray start a hundred cycles into a pass, then repeats the pass and checks that neither pass was disturbed.

// File: rtl/ecmf_pkg.sv
package ecmf_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ACC,
      ST_EMIT,
      ST_FIN
   } ecmf_state_e;

endpackage

// File: rtl/ecmf_window.sv
module ecmf_window #(
   parameter int CHIPS = 62,
   parameter int SMP_W = 12,
   localparam int CID_W = $clog2(CHIPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    shift_en,
   input  logic signed [SMP_W-1:0] din,
   input  logic [CID_W-1:0]        rd_idx,
   output logic signed [SMP_W-1:0] rd_data
);

   // entry 0 is the oldest sample, entry CHIPS-1 the newest
   logic signed [SMP_W-1:0] win [CHIPS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CHIPS; i++) win[i] <= '0;
      end else if (shift_en) begin
         for (int i = 0; i < CHIPS - 1; i++) win[i] <= win[i+1];
         win[CHIPS-1] <= din;
      end
   end

   assign rd_data = win[rd_idx];

endmodule

// File: rtl/ecmf_coef_mem.sv
module ecmf_coef_mem #(
   parameter int NUM_USERS = 15,
   parameter int CHIPS     = 62,
   parameter int COEF_W    = 12,
   parameter int LANES     = 2,
   parameter int UB_W      = 5,
   localparam int UID_W  = $clog2(NUM_USERS),
   localparam int CID_W  = $clog2(CHIPS),
   localparam int DEPTH  = NUM_USERS * CHIPS,
   localparam int MEM_AW = $clog2(DEPTH)
) (
   input  logic                      clk,
   input  logic                      we,
   input  logic [UID_W-1:0]          wr_user,
   input  logic [CID_W-1:0]          wr_chip,
   input  logic signed [COEF_W-1:0]  wr_data,
   input  logic [UB_W-1:0]           rd_base,
   input  logic [CID_W-1:0]          rd_chip,
   output logic [LANES*COEF_W-1:0]   rd_data
);

   logic signed [COEF_W-1:0] mem [DEPTH];
   logic                     wr_ok;

   assign wr_ok = we && (int'(wr_user) < NUM_USERS) && (int'(wr_chip) < CHIPS);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[MEM_AW'(int'(wr_user) * CHIPS + int'(wr_chip))] <= wr_data;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_rd
      logic [UB_W-1:0] usr;
      assign usr = rd_base + UB_W'(l);
      assign rd_data[l*COEF_W +: COEF_W] = (int'(usr) < NUM_USERS)
         ? mem[MEM_AW'(int'(usr) * CHIPS + int'(rd_chip))] : '0;
   end

endmodule

// File: rtl/ecmf_mac_lane.sv
module ecmf_mac_lane #(
   parameter int SMP_W  = 12,
   parameter int COEF_W = 12,
   parameter int ACC_W  = 24,
   parameter int OUT_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [SMP_W-1:0]  samp,
   input  logic signed [COEF_W-1:0] coef,
   output logic signed [OUT_W-1:0]  stat
);

   localparam int PROD_W = SMP_W + COEF_W;
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   logic signed [PROD_W-1:0] prod;
   logic signed [ACC_W:0]    sum;
   logic signed [ACC_W-1:0]  acc, acc_nx;

   assign prod = samp * coef;
   assign sum  = (ACC_W+1)'(acc) + (ACC_W+1)'(prod);

   always_comb begin
      if (sum[ACC_W] != sum[ACC_W-1]) acc_nx = sum[ACC_W] ? ACC_MIN : ACC_MAX;
      else                            acc_nx = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc_nx;
   end

   if (OUT_W == ACC_W) begin : g_out_full
      assign stat = acc;
   end else begin : g_out_clamp
      logic [ACC_W-OUT_W:0] top;
      logic                 fits;
      assign top  = acc[ACC_W-1:OUT_W-1];
      assign fits = (&top) | ~(|top);
      assign stat = fits ? acc[OUT_W-1:0]
                  : (acc[ACC_W-1] ? {1'b1, {(OUT_W-1){1'b0}}} : {1'b0, {(OUT_W-1){1'b1}}});
   end

endmodule

// File: rtl/ecmf_bank.sv
module ecmf_bank
   import ecmf_pkg::*;
#(
   parameter int NUM_USERS = 15,
   parameter int SPREAD    = 31,
   parameter int LANES     = 2,
   parameter int SMP_W     = 12,
   parameter int COEF_W    = 12,
   parameter int ACC_W     = 24,
   parameter int OUT_W     = 16,
   localparam int CHIPS = 2 * SPREAD,
   localparam int UID_W = $clog2(NUM_USERS),
   localparam int CID_W = $clog2(CHIPS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_valid,
   input  logic signed [SMP_W-1:0]  smp_data,
   input  logic                     coef_we,
   input  logic [UID_W-1:0]         coef_user,
   input  logic [CID_W-1:0]         coef_chip,
   input  logic signed [COEF_W-1:0] coef_data,
   input  logic                     start,
   output logic                     stat_valid,
   output logic [UID_W-1:0]         stat_user,
   output logic signed [OUT_W-1:0]  stat_data,
   output logic                     done
);

   localparam int UB_W  = $clog2(NUM_USERS + LANES) + 1;
   localparam int LID_W = (LANES > 1) ? $clog2(LANES) : 1;

   if (NUM_USERS < 2)                    $error("NUM_USERS must be at least 2");
   if (LANES < 1 || LANES > NUM_USERS)   $error("LANES out of range");
   if (SPREAD < 2)                       $error("SPREAD must be at least 2");
   if (ACC_W < SMP_W + COEF_W)           $error("ACC_W narrower than a product");
   if (OUT_W > ACC_W || OUT_W < 2)       $error("OUT_W out of range");

   ecmf_state_e              state;
   logic [UB_W-1:0]          base_user, cur_user;
   logic [CID_W-1:0]         chip;
   logic [LID_W-1:0]         lane;
   logic                     busy, last_chip, grp_end, last_grp, mac_clr, mac_en;
   logic signed [SMP_W-1:0]  win_rd;
   logic [LANES*COEF_W-1:0]  coef_rd;
   logic signed [OUT_W-1:0]  lane_stat [LANES];

   assign busy      = (state != ST_IDLE);
   assign last_chip = (chip == CID_W'(CHIPS - 1));
   assign cur_user  = base_user + UB_W'(lane);
   assign grp_end   = (lane == LID_W'(LANES - 1)) || (int'(cur_user) + 1 >= NUM_USERS);
   assign last_grp  = (int'(base_user) + LANES >= NUM_USERS);
   assign mac_clr   = ((state == ST_IDLE) && start) ||
                      ((state == ST_EMIT) && grp_end && !last_grp);
   assign mac_en    = (state == ST_ACC);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         base_user <= '0;
         chip      <= '0;
         lane      <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               state     <= ST_ACC;
               base_user <= '0;
               chip      <= '0;
               lane      <= '0;
            end
            ST_ACC: if (last_chip) begin
               state <= ST_EMIT;
               lane  <= '0;
            end else begin
               chip <= chip + 1'b1;
            end
            ST_EMIT: if (grp_end) begin
               if (last_grp) begin
                  state <= ST_FIN;
               end else begin
                  state     <= ST_ACC;
                  base_user <= base_user + UB_W'(LANES);
                  chip      <= '0;
               end
            end else begin
               lane <= lane + 1'b1;
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   ecmf_window #(.CHIPS(CHIPS), .SMP_W(SMP_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (smp_valid && !busy),
      .din      (smp_data),
      .rd_idx   (chip),
      .rd_data  (win_rd)
   );

   ecmf_coef_mem #(
      .NUM_USERS (NUM_USERS),
      .CHIPS     (CHIPS),
      .COEF_W    (COEF_W),
      .LANES     (LANES),
      .UB_W      (UB_W)
   ) u_mem (
      .clk     (clk),
      .we      (coef_we && !busy),
      .wr_user (coef_user),
      .wr_chip (coef_chip),
      .wr_data (coef_data),
      .rd_base (base_user),
      .rd_chip (chip),
      .rd_data (coef_rd)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      ecmf_mac_lane #(
         .SMP_W  (SMP_W),
         .COEF_W (COEF_W),
         .ACC_W  (ACC_W),
         .OUT_W  (OUT_W)
      ) u_lane (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (mac_clr),
         .en    (mac_en),
         .samp  (win_rd),
         .coef  (coef_rd[l*COEF_W +: COEF_W]),
         .stat  (lane_stat[l])
      );
   end

   assign stat_valid = (state == ST_EMIT);
   assign stat_user  = UID_W'(cur_user);
   assign stat_data  = lane_stat[lane];
   assign done       = (state == ST_FIN);

endmodule

// File: rtl/ecmf_bank_chk.sv
module ecmf_bank_chk #(
   parameter int NUM_USERS = 15,
   parameter int UID_W     = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_valid,
   input logic [UID_W-1:0] stat_user,
   input logic             done
);

   // R4
   user_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && $past(stat_valid)) |-> (stat_user == UID_W'($past(stat_user) + 1'b1)));

   // R4
   user_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> (int'(stat_user) < NUM_USERS));

   // R5
   done_follows_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(stat_valid) && ($past(stat_user) == UID_W'(NUM_USERS - 1))));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && stat_valid));

endmodule

bind ecmf_bank ecmf_bank_chk #(.NUM_USERS(NUM_USERS), .UID_W(UID_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stat_valid (stat_valid),
   .stat_user  (stat_user),
   .done       (done)
);

// File: tb/tb_ecmf_bank.sv
module tb_ecmf_bank;

   localparam int NU = 15;
   localparam int CH = 62;
   localparam int LN = 2;
   localparam int NG = (NU + LN - 1) / LN;
   localparam int DONE_N = CH + (NG - 1) * (CH + LN) + (NU - (NG - 1) * LN);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic signed [11:0] smp_data = '0;
   logic coef_we = 1'b0;
   logic [3:0] coef_user = '0;
   logic [5:0] coef_chip = '0;
   logic signed [11:0] coef_data = '0;
   logic start = 1'b0;
   logic stat_valid;
   logic [3:0] stat_user;
   logic signed [15:0] stat_data;
   logic done;

   always #10 clk = ~clk;

   ecmf_bank dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .coef_we(coef_we), .coef_user(coef_user), .coef_chip(coef_chip),
      .coef_data(coef_data), .start(start), .stat_valid(stat_valid),
      .stat_user(stat_user), .stat_data(stat_data), .done(done)
   );

   int total = 0;
   int bad = 0;
   string tag = "R1";

   int mcoef [NU][CH];
   int mwin [CH];
   int mexp [NU];
   bit m_busy = 1'b0;
   int n = 0;

   task automatic check(bit ok, string rq, string what, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
      end
   endtask

   function automatic int clamp(int v, int w);
      int hi = (1 << (w - 1)) - 1;
      int lo = -(1 << (w - 1));
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

   function automatic int exp_user(int k);
      for (int g = 0; g < NG; g++) begin
         int s = CH + g * (CH + LN);
         for (int o = 0; o < LN; o++)
            if (g * LN + o < NU && k == s + o) return g * LN + o;
      end
      return -1;
   endfunction

   task automatic compute_exp();
      for (int u = 0; u < NU; u++) begin
         longint a = 0;
         for (int j = 0; j < CH; j++) begin
            a = a + longint'(mcoef[u][j]) * longint'(mwin[j]);
            if (a > 8388607) a = 8388607;
            if (a < -8388608) a = -8388608;
         end
         mexp[u] = clamp(int'(a), 16);
      end
   endtask

   initial begin
      for (int u = 0; u < NU; u++) for (int j = 0; j < CH; j++) mcoef[u][j] = 0;
      for (int j = 0; j < CH; j++) mwin[j] = 0;
   end

   // reference model and per-cycle comparison
   always @(posedge clk) begin
      #5;
      if (rst_n) begin
         if (m_busy) begin
            int eu;
            n++;
            eu = exp_user(n);
            if (n == DONE_N + 1) m_busy = 1'b0;
            if (eu >= 0) begin
               check(stat_valid == 1'b1, "R4", "valid", int'(stat_valid), 1);
               check(int'(stat_user) == eu, "R4", "user", int'(stat_user), eu);
               check(int'(stat_data) == mexp[eu], tag, "stat", int'(stat_data), mexp[eu]);
            end else begin
               check(stat_valid == 1'b0, "R4", "spurious valid", int'(stat_valid), 0);
            end
            check(done == (n == DONE_N), "R5", "done", int'(done), int'(n == DONE_N));
         end else begin
            check(!stat_valid && !done, "R5", "idle outputs", int'({stat_valid, done}), 0);
            if (coef_we && int'(coef_user) < NU && int'(coef_chip) < CH)
               mcoef[coef_user][coef_chip] = int'(coef_data);
            if (smp_valid) begin
               for (int j = 0; j < CH - 1; j++) mwin[j] = mwin[j+1];
               mwin[CH-1] = int'(smp_data);
            end
            if (start) begin
               m_busy = 1'b1;
               n = 0;
               compute_exp();
            end
         end
      end
   end

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr(int u, int c, int v);
      @(negedge clk);
      coef_we = 1'b1; coef_user = 4'(u); coef_chip = 6'(c); coef_data = 12'(v);
   endtask

   task automatic wr_end();
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   task automatic push(int v);
      @(negedge clk);
      smp_valid = 1'b1; smp_data = 12'(v);
   endtask

   task automatic push_end();
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic run_pass(string t);
      tag = t;
      pulse_start();
      wait (m_busy);
      wait (!m_busy);
      repeat (3) @(negedge clk);
   endtask

   function automatic int rnd12();
      return int'($urandom_range(0, 4095)) - 2048;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check(!stat_valid && !done, "R10", "reset outputs", int'({stat_valid, done}), 0);
      rst_n = 1'b1;

      for (int u = 0; u < NU; u++) for (int j = 0; j < CH; j++) wr(u, j, rnd12());
      wr_end();
      run_pass("R10");                       // zero window after reset

      for (int j = 0; j < CH; j++) push(int'($urandom_range(0, 200)) - 100);
      push_end();
      run_pass("R1");                        // random small values

      for (int j = 0; j < 20; j++) push(rnd12());
      push_end();
      run_pass("R1");                        // full-range window, shared across users

      // R2 R3: saturation corners with full-scale positive window
      for (int j = 0; j < CH; j++) push(2047);
      push_end();
      for (int j = 0; j < CH; j++) begin
         wr(0, j, 2047);
         wr(1, j, -2048);
         wr(2, j, (j < CH / 2) ? 2047 : -2048);
         wr(3, j, 20);
         wr(4, j, (j < 2) ? 2047 : -3);
      end
      wr_end();
      run_pass("R2 R3");

      // R6 R7 R8: disturbances in the middle of a pass
      tag = "R6 R7 R8";
      pulse_start();
      wait (m_busy);
      repeat (100) @(negedge clk);
      wr(0, 0, -2048);
      wr(5, 10, 1234);
      wr_end();
      push(-2048);
      push(777);
      push_end();
      pulse_start();
      wait (!m_busy);
      repeat (3) @(negedge clk);
      run_pass("R6 R7");                     // coefficients and window unchanged

      // R9: out-of-range chip and user indices
      wr(0, 62, -2048);
      wr(0, 63, -2048);
      wr(15, 0, -2048);
      wr_end();
      for (int j = 0; j < CH; j++) push(int'($urandom_range(0, 600)) - 300);
      push_end();
      run_pass("R9");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule